// File: doc/BRIEF.md
# Command Slot Issue Tracker

This block keeps the command-issue state of a multi-channel disk controller, with up to eight channels. Each channel has 32 command slots. Software posts a command by writing a 1 to that slot's bit in the channel's issue vector. While the channel's run control is nonzero, the block offers pending slots one at a time to a transfer engine on a valid/ready dispatch port. Each channel has its own dispatch port.

The engine reports that a slot has finished with a single-cycle completion pulse that carries the slot number. The block then clears the slot's issue bit and latches a completion flag in the channel's status register. If the channel's interrupt enable is set, it raises the channel interrupt. The interrupt belongs to the channel and does not say which command finished. Software acknowledges it by writing a 1 to the status flag.

All per-channel registers are reached through a simple register port. The word address is formed as {channel, register index}. Writes take effect at the clock edge. Reads are combinational.

Top module: `cmd_slot_tracker`

## Requirements
- R1: After reset, every register reads 0, every dispatch valid is low and every interrupt is low.
- R2: Register index 0 holds the list base low word and index 1 the high word. Bits 3:0 of the low word always read 0 (16-byte alignment). All other bits of both words store what was written.
- R3: Register index 5 is the issue vector. Writing it sets every slot whose data bit is 1. A 0 data bit has no effect, so software cannot cancel a pending slot.
- R4: Register index 4 is run control, a full 32-bit word. A channel offers slots only while this word is nonzero. Once it is written to 0, dispatch valid drops in the next cycle.
- R5: Among slots that are pending and not yet handed out, the offered slot is the first one found searching upward, with wrap-around, from the slot after the most recently dispatched one. After reset the search starts at slot 0.
- R6: A slot handed out by a valid/ready handshake is not offered again until its completion pulse arrives.
- R7: A completion pulse for slot s clears issue bit s and sets status bit 0, both visible the next cycle. A software set of slot s in the same cycle wins, and the slot becomes pending again.
- R8: Register index 3 bit 0 is the interrupt enable. The channel interrupt equals status bit 0 AND enable bit 0, both taken from registers.
- R9: Register index 2 is the status register. Writing a 1 to bit 0 clears it, and writing 0 leaves it unchanged. A completion in the same cycle as the clear keeps the bit set.
- R10: Channels are independent. A write or completion on one channel changes no register, dispatch or interrupt of another channel.
- R11: Indices 6 and 7, and channel numbers at or above the channel count, read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | CW+3 | Word address {channel, index} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| disp_valid | output | NCH | Per-channel slot offer valid |
| disp_ready | input | NCH | Per-channel engine accepts the offer |
| disp_slot | output | NCH*SW | Per-channel offered slot number |
| done_valid | input | NCH | Per-channel completion pulse |
| done_slot | input | NCH*SW | Per-channel completed slot number |
| irq | output | NCH | Per-channel interrupt |

## Verification
Read data is due in the same cycle its address is presented. A register write, a dispatch handshake or a completion becomes visible one rising edge later, in read data, the next offered slot, the status flag and the interrupt. The bench drives its inputs just after the falling edge. It then updates a behavioural model with the same inputs and, one full cycle later at the next falling edge, compares every output port against that model. No result is sampled near the edge that produces it.

// File: rtl/cmd_slot_tracker.sv
module cmd_slot_tracker #(
  parameter int NCH   = 3,
  parameter int NSLOT = 32,
  localparam int SW   = $clog2(NSLOT),
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW   = CW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NCH-1:0]    disp_valid,
  input  logic [NCH-1:0]    disp_ready,
  output logic [NCH*SW-1:0] disp_slot,
  input  logic [NCH-1:0]    done_valid,
  input  logic [NCH*SW-1:0] done_slot,
  output logic [NCH-1:0]    irq
);

  localparam int NPAD = 1 << CW;

  logic [CW-1:0] a_ch;
  logic [2:0]    a_ix;
  assign a_ch = reg_addr[AW-1:3];
  assign a_ix = reg_addr[2:0];

  logic [NPAD-1:0][31:0]    rd_v;
  logic [NCH-1:0][NSLOT-1:0] ci_v, inf_v;
  logic [NCH-1:0][31:0]     run_v;
  logic [NCH-1:0]           st_v, ie_v;

  assign reg_rdata = rd_v[a_ch];

  for (genvar c = 0; c < NPAD; c++) begin : g_ch
    if (c < NCH) begin : ch
      logic [31:0]      lo, hi, run;
      logic             st, ie;
      logic [NSLOT-1:0] ci, inf, elig, dmask, fmask, smask;
      logic [SW-1:0]    last, sel;
      logic             hit, wsel, fire;

      assign wsel  = reg_we && (a_ch == CW'(c));
      assign elig  = ci & ~inf;
      assign fire  = disp_valid[c] && disp_ready[c];
      assign dmask = done_valid[c] ? (NSLOT'(1) << done_slot[c*SW +: SW]) : '0;
      assign fmask = fire ? (NSLOT'(1) << sel) : '0;
      assign smask = (wsel && a_ix == 3'd5) ? reg_wdata[NSLOT-1:0] : '0;

      always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = 1; i <= NSLOT; i++) begin
          if (!hit && elig[SW'((int'(last) + i) % NSLOT)]) begin
            hit = 1'b1;
            sel = SW'((int'(last) + i) % NSLOT);
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          lo   <= '0;
          hi   <= '0;
          run  <= '0;
          st   <= 1'b0;
          ie   <= 1'b0;
          ci   <= '0;
          inf  <= '0;
          last <= SW'(NSLOT - 1);
        end else begin
          ci   <= (ci & ~dmask) | smask;
          inf  <= (inf | fmask) & ~dmask;
          if (fire) last <= sel;
          st   <= done_valid[c] | (st & ~(wsel && a_ix == 3'd2 && reg_wdata[0]));
          if (wsel) begin
            case (a_ix)
              3'd0: lo  <= {reg_wdata[31:4], 4'b0};
              3'd1: hi  <= reg_wdata;
              3'd3: ie  <= reg_wdata[0];
              3'd4: run <= reg_wdata;
              default: ;
            endcase
          end
        end
      end

      always_comb begin
        case (a_ix)
          3'd0:    rd_v[c] = lo;
          3'd1:    rd_v[c] = hi;
          3'd2:    rd_v[c] = {31'b0, st};
          3'd3:    rd_v[c] = {31'b0, ie};
          3'd4:    rd_v[c] = run;
          3'd5:    rd_v[c] = 32'(ci);
          default: rd_v[c] = '0;
        endcase
      end

      assign disp_valid[c]          = hit && (run != '0);
      assign disp_slot[c*SW +: SW]  = sel;
      assign irq[c]                 = st & ie;
      assign ci_v[c]  = ci;
      assign inf_v[c] = inf;
      assign run_v[c] = run;
      assign st_v[c]  = st;
      assign ie_v[c]  = ie;
    end else begin : pad
      assign rd_v[c] = '0;
    end
  end

endmodule

module cmd_slot_tracker_chk #(
  parameter int NCH   = 3,
  parameter int NSLOT = 32,
  parameter int SW    = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            disp_valid,
  input logic [NCH-1:0]            disp_ready,
  input logic [NCH*SW-1:0]         disp_slot,
  input logic [NCH-1:0]            done_valid,
  input logic [NCH-1:0]            irq,
  input logic [NCH-1:0][NSLOT-1:0] ci_v,
  input logic [NCH-1:0][NSLOT-1:0] inf_v,
  input logic [NCH-1:0][31:0]      run_v,
  input logic [NCH-1:0]            st_v,
  input logic [NCH-1:0]            ie_v
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    a_r4_run_gate: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid[c] |-> (run_v[c] != '0));
    a_r6_offer_fresh: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid[c] |-> (ci_v[c][disp_slot[c*SW +: SW]] && !inf_v[c][disp_slot[c*SW +: SW]]));
    a_r6_handout_held: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid[c] && disp_ready[c] && !done_valid[c]) |=> inf_v[c][$past(disp_slot[c*SW +: SW])]);
    a_r3_no_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !done_valid[c] |=> ((ci_v[c] & $past(ci_v[c])) == $past(ci_v[c])));
    a_r7_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid[c] |=> st_v[c]);
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[c]) |-> ($past(done_valid[c]) || $rose(ie_v[c])));
  end
endmodule

bind cmd_slot_tracker cmd_slot_tracker_chk #(.NCH(NCH), .NSLOT(NSLOT), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_slot(disp_slot), .done_valid(done_valid), .irq(irq), .ci_v(ci_v),
  .inf_v(inf_v), .run_v(run_v), .st_v(st_v), .ie_v(ie_v)
);

// File: tb/tb_cmd_slot_tracker.sv
`timescale 1ns/1ps
module tb_cmd_slot_tracker;
  localparam int NCH = 3, NSLOT = 32, SW = 5, CW = 2, AW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              reg_we = 1'b0;
  logic [AW-1:0]     reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NCH-1:0]    disp_valid, disp_ready = '0, done_valid = '0, irq;
  logic [NCH*SW-1:0] disp_slot, done_slot = '0;

  cmd_slot_tracker #(.NCH(NCH), .NSLOT(NSLOT)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .disp_slot(disp_slot), .done_valid(done_valid),
    .done_slot(done_slot), .irq(irq));

  logic [31:0] m_lo[NCH], m_hi[NCH], m_run[NCH], m_ci[NCH], m_inf[NCH];
  bit m_st[NCH], m_ie[NCH];
  int m_last[NCH];
  int errors = 0, checks = 0;
  bit fin = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_pick(int c, output bit found);
    found = 0;
    for (int i = 1; i <= NSLOT; i++) begin
      int k = (m_last[c] + i) % NSLOT;
      if (m_ci[c][k] && !m_inf[c][k]) begin found = 1; return k; end
    end
    return 0;
  endfunction

  function automatic logic [31:0] m_read(logic [AW-1:0] a);
    int ch = int'(a[AW-1:3]);
    if (ch >= NCH) return 0;
    case (a[2:0])
      3'd0: return m_lo[ch];
      3'd1: return m_hi[ch];
      3'd2: return {31'b0, m_st[ch]};
      3'd3: return {31'b0, m_ie[ch]};
      3'd4: return m_run[ch];
      3'd5: return m_ci[ch];
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(logic [AW-1:0] a);
    if (int'(a[AW-1:3]) >= NCH) return "R11 unmapped channel";
    case (a[2:0])
      3'd0, 3'd1: return "R2 list base";
      3'd2: return "R9 status";
      3'd3: return "R8 enable";
      3'd4: return "R4 run";
      3'd5: return "R3 issue";
      default: return "R11 unmapped index";
    endcase
  endfunction

  task automatic m_reset();
    for (int c = 0; c < NCH; c++) begin
      m_lo[c] = 0; m_hi[c] = 0; m_run[c] = 0; m_ci[c] = 0; m_inf[c] = 0;
      m_st[c] = 0; m_ie[c] = 0; m_last[c] = NSLOT - 1;
    end
  endtask

  task automatic tick();
    #1;
    chk(tag_of(reg_addr), reg_rdata, m_read(reg_addr));
    for (int c = 0; c < NCH; c++) begin
      bit f;
      int k = m_pick(c, f);
      bit ev = f && (m_run[c] != 0);
      bit wsel = reg_we && (int'(reg_addr[AW-1:3]) == c);
      logic [31:0] dm = done_valid[c] ? (32'd1 << done_slot[c*SW +: SW]) : 32'd0;
      logic [31:0] sm = (wsel && reg_addr[2:0] == 3'd5) ? reg_wdata : 32'd0;
      chk("R4 R10 dispatch valid", 32'(disp_valid[c]), 32'(ev));
      if (ev) chk("R5 R6 offered slot", 32'(disp_slot[c*SW +: SW]), 32'(k));
      chk("R8 interrupt", 32'(irq[c]), 32'(m_st[c] & m_ie[c]));
      m_ci[c]  = (m_ci[c] & ~dm) | sm;
      m_inf[c] = (m_inf[c] | ((ev && disp_ready[c]) ? (32'd1 << k) : 32'd0)) & ~dm;
      if (ev && disp_ready[c]) m_last[c] = k;
      m_st[c] = done_valid[c] | (m_st[c] & !(wsel && reg_addr[2:0] == 3'd2 && reg_wdata[0]));
      if (wsel) case (reg_addr[2:0])
        3'd0: m_lo[c] = reg_wdata & ~32'hF;
        3'd1: m_hi[c] = reg_wdata;
        3'd3: m_ie[c] = reg_wdata[0];
        3'd4: m_run[c] = reg_wdata;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int ch, int ix, logic [31:0] d);
    reg_we = 1; reg_addr = AW'({ch[CW-1:0], ix[2:0]}); reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd(int ch, int ix);
    reg_addr = AW'({ch[CW-1:0], ix[2:0]});
    tick();
  endtask

  task automatic done(int ch, int s);
    done_valid[ch] = 1; done_slot[ch*SW +: SW] = SW'(s);
    tick();
    done_valid[ch] = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 valid after reset", 32'(disp_valid), 0);
    chk("R1 irq after reset", 32'(irq), 0);
    for (int i = 0; i < 8; i++) rd(0, i);
    // R2: alignment
    wr(0, 0, 32'hFFFF_FFFF); rd(0, 0);
    chk("R2 low word aligned", reg_rdata, 32'hFFFF_FFF0);
    wr(0, 1, 32'hA5A5_0001); rd(0, 1);
    // R4: posted but stopped
    wr(0, 5, 32'h0000_0013); rd(0, 5); rd(0, 5);
    chk("R4 no offer while stopped", 32'(disp_valid[0]), 0);
    // R3: zero write no effect
    wr(0, 5, 32'h0); rd(0, 5);
    chk("R3 zero write keeps slots", reg_rdata, 32'h13);
    // R10: channel 1 untouched
    rd(1, 5);
    chk("R10 other channel idle", reg_rdata, 0);
    // R5 R6: dispatch order 0,1,4
    wr(0, 3, 1); wr(0, 4, 32'h100);
    chk("R5 first slot", 32'(disp_slot[SW-1:0]), 0);
    disp_ready[0] = 1;
    rd(0, 5); rd(0, 5); rd(0, 5);
    chk("R6 nothing left to offer", 32'(disp_valid[0]), 0);
    wr(0, 5, 32'h1); rd(0, 5);
    chk("R6 in-flight slot not reoffered", 32'(disp_valid[0]), 0);
    // R7 R8: completion
    done(0, 1); rd(0, 5);
    chk("R7 slot bit cleared", reg_rdata, 32'h11);
    chk("R8 irq raised", 32'(irq[0]), 1);
    // R9: clear semantics
    wr(0, 2, 0); rd(0, 2);
    chk("R9 zero write keeps flag", reg_rdata, 1);
    wr(0, 2, 1); rd(0, 2);
    chk("R9 flag cleared", reg_rdata, 0);
    // R9: completion beats clear
    done_valid[0] = 1; done_slot[SW-1:0] = 5'd4;
    wr(0, 2, 1); done_valid[0] = 0; rd(0, 2);
    chk("R9 completion wins over clear", reg_rdata, 1);
    // R5 wrap: last=4, post 31 and 2
    disp_ready[0] = 0;
    wr(0, 5, 32'h8000_0004); rd(0, 5);
    chk("R5 wrap picks 31", 32'(disp_slot[SW-1:0]), 31);
    disp_ready[0] = 1; rd(0, 5);
    chk("R5 then 2", 32'(disp_slot[SW-1:0]), 2);
    rd(0, 5); disp_ready[0] = 0;
    // R7: set and completion same slot
    done_valid[0] = 1; done_slot[SW-1:0] = 5'd31;
    wr(0, 5, 32'h8000_0000); done_valid[0] = 0; rd(0, 5);
    chk("R7 set wins over completion", reg_rdata[31], 1);
    // R4: stop
    wr(0, 4, 0); rd(0, 4);
    chk("R4 stop drops valid", 32'(disp_valid[0]), 0);
    // R11
    wr(3, 0, 32'hFFFF_FFFF); wr(1, 6, 32'hFFFF_FFFF); rd(3, 0); rd(1, 6); rd(1, 0);
    chk("R11 unmapped write ignored", reg_rdata, 0);
    // random traffic on all channels
    for (int n = 0; n < 600; n++) begin
      disp_ready = NCH'($urandom);
      for (int c = 0; c < NCH; c++) begin
        if (m_inf[c] != 0 && ($urandom % 3 == 0)) begin
          int s0 = int'($urandom % NSLOT);
          for (int j = 0; j < NSLOT; j++)
            if (!done_valid[c] && m_inf[c][(s0 + j) % NSLOT]) begin
              done_valid[c] = 1; done_slot[c*SW +: SW] = SW'((s0 + j) % NSLOT);
            end
        end
      end
      if ($urandom % 4 == 0) begin
        int ix = ($urandom % 3 == 0) ? int'($urandom % 8) : 5;
        int d  = int'($urandom);
        if (ix == 4) d = ($urandom % 4 == 0) ? 0 : 1;
        reg_we = 1; reg_addr = AW'($urandom); reg_addr[2:0] = 3'(ix); reg_wdata = d;
      end else begin
        reg_addr = AW'($urandom);
      end
      tick();
      reg_we = 0; done_valid = '0;
    end
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule